// File: doc/BRIEF.md
# Event Counter Access Permission Checker

This block decides, in a single combinational step, what happens when an instruction tries to read or write one of the numbered event counter registers through the system-register space. It first checks whether the five encoding fields of the instruction name an event counter, and if they do it extracts the counter index. It then works through a fixed, ordered list of conditions. The list differs between the four exception levels and between reads and writes. The inputs are the counter feature flags, the hypervisor and monitor trap-control bits, the user-enable bits and a per-counter user-access mask.

The result comes out as a one-hot vector over six outcome kinds, together with the decoded index, a hit flag and the exception class code that any trap must report. Some situations are left open by the architecture. A parameter resolves each of them to a single fixed outcome, so the block is always deterministic. The surrounding pipeline uses the outcome to either perform the access, return zero or drop the write, raise an undefined-instruction exception, or take a trap to the indicated level.

Top module: `ctr_access_perm`

## Requirements
- R1: `hit` is 1 only when op0=3, op1=3, CRn=14, CRm[3:2]=2'b10 and the index {CRm[1:0],op2} is at most 30. In that case `ctr_idx` equals that index. The outcome bits are [0] access, [1] read-zero/write-ignored, [2] undefined, [3] trap to EL1, [4] trap to EL2, [5] trap to EL3. Exactly one bit is set when `hit` is 1, and none when `hit` is 0.
- R2: If the counter feature is absent, every hit gives undefined. This is the highest-priority check.
- R3: The second check is an index at or above `impl_cnt`. It gives undefined when the fine-grained trap feature is present, and the unpredictable resolution otherwise.
- R4: At EL0, EL1 and EL2, the first level-specific check is the monitor trap bit combined with the secure-debug-priority flag, with EL3 implemented. If all three hold, the result is undefined.
- R5: At EL0, a read is denied when the user enable bits are all clear. Those bits are the all-enable, read-enable and general-enable bits when the newer user-access feature is present, and only read-enable and general-enable when it is absent. A write is denied when general-enable is clear and either all-enable is clear or the newer feature is absent. A denied access traps to EL2 if EL2 is enabled and the host-general-trap bit is set, and to EL1 otherwise.
- R6: The fine-grained trap uses the read bit for reads and the write bit for writes, and traps to EL2. It applies only when EL2 is enabled, the feature is present, and either EL3 is absent or its fine-grained enable is set. At EL0 it is also skipped when running in host mode. At EL0 and EL1 it is checked right after the R4 and R5 checks.
- R7: Next, with EL2 enabled, the hypervisor trap bit traps to EL2. After that, an index at or above `acc_cnt` traps to EL2 if the fine-grained feature is present, and otherwise gives the unpredictable resolution.
- R8: Next, the monitor trap bit with EL3 implemented gives undefined when the secure-debug-undefined flag is set, and a trap to EL3 otherwise.
- R9: At EL2 only the R4 and R8 checks apply. At EL3 every access that passes R2 and R3 is permitted.
- R10: At EL0, an access that passes every trap gives read-zero/write-ignored when the newer feature is present, all-enable is set, and the per-counter mask bit is clear. For a write, the same outcome also applies when the mask bit is set but read-enable is set.
- R11: With `UNPRED_AS_UNDEF`=1 (the default), an unpredictable case gives undefined. With 0, it gives read-zero/write-ignored.
- R12: `ec` is 6'h18 whenever any trap outcome bit is set, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| is_write | input | 1 | 1 for a register write, 0 for a read |
| enc_op0 | input | 2 | encoding field op0 |
| enc_op1 | input | 3 | encoding field op1 |
| enc_crn | input | 4 | encoding field CRn |
| enc_crm | input | 4 | encoding field CRm |
| enc_op2 | input | 3 | encoding field op2 |
| cur_el | input | 2 | current exception level, 0 to 3 |
| has_ctr | input | 1 | counter feature present |
| has_fgt | input | 1 | fine-grained trap feature present |
| has_uacc | input | 1 | newer user-access feature present |
| has_el3 | input | 1 | EL3 implemented |
| el2_en | input | 1 | EL2 enabled in the current security state |
| el0_host | input | 1 | EL0 runs in host mode |
| host_tge | input | 1 | host-general-trap bit |
| hyp_trap | input | 1 | hypervisor counter trap bit |
| mon_trap | input | 1 | monitor counter trap bit |
| mon_fgt_en | input | 1 | monitor fine-grained trap enable |
| sdd_prio | input | 1 | secure-debug-undefined with priority |
| sdd_undef | input | 1 | secure-debug-undefined |
| fgt_rd | input | 1 | fine-grained read trap bit for these counters |
| fgt_wr | input | 1 | fine-grained write trap bit for these counters |
| usr_all | input | 1 | user all-enable bit |
| usr_rd | input | 1 | user read-enable bit |
| usr_gen | input | 1 | user general-enable bit |
| usr_mask | input | 31 | per-counter user-access mask |
| impl_cnt | input | 6 | number of implemented counters |
| acc_cnt | input | 6 | number of counters accessible below EL2 |
| hit | output | 1 | encoding names an event counter |
| ctr_idx | output | 5 | decoded counter index |
| outcome | output | 6 | one-hot outcome kind |
| ec | output | 6 | exception class for traps |

## Verification
The hardest outcomes to reach from the ports are the ones at the bottom of the EL0 chain: a plain access and the read-zero/write-ignored result. Both require every enable to be in a permissive state and every one of the roughly ten trap conditions ahead of them to be quiet. A sweep with independently flipped control bits seldom gets there. Directed vectors therefore set each trap source in isolation against an otherwise permissive baseline. A long pseudo-random sweep then covers every level and direction, with the trap bits biased towards clear. Each sweep vector is compared against a priority model written in the bench from the requirements.

// File: rtl/ctrperm_pkg.sv
package ctrperm_pkg;

   localparam int OUT_W = 6;
   localparam int BIT_ACCESS = 0;
   localparam int BIT_ZERO   = 1;
   localparam int BIT_UNDEF  = 2;
   localparam int BIT_TRAP1  = 3;
   localparam int BIT_TRAP2  = 4;
   localparam int BIT_TRAP3  = 5;

   localparam logic [5:0] TRAP_EC = 6'h18;

   typedef enum logic [2:0] {
      K_NONE,
      K_ACCESS,
      K_ZERO,
      K_UNDEF,
      K_TRAP1,
      K_TRAP2,
      K_TRAP3,
      K_UNPRED
   } kind_e;

   typedef struct packed {
      logic impl_over;
      logic acc_over;
      logic user_deny;
      logic user_to_el2;
      logic fgt_el1;
      logic fgt_el0;
      logic hyp_on;
      logic mon_prio;
      logic mon_on;
      logic zero_user;
   } cond_t;

endpackage

// File: rtl/ctrperm_decode.sv
module ctrperm_decode #(
   parameter int IDX_W   = 5,
   parameter int MAX_IDX = 30
) (
   input  logic [1:0]       op0,
   input  logic [2:0]       op1,
   input  logic [3:0]       crn,
   input  logic [3:0]       crm,
   input  logic [2:0]       op2,
   output logic             hit,
   output logic [IDX_W-1:0] idx
);
   localparam int HI_W = IDX_W - 3;

   logic [4:0] raw_idx;
   logic       fixed_ok;

   assign raw_idx  = {crm[1:0], op2};
   assign fixed_ok = (op0 == 2'd3) && (op1 == 3'd3) && (crn == 4'd14) &&
                     (crm[3:2] == 2'b10);

   generate
      if (IDX_W == 5) begin : g_full
         assign idx = raw_idx;
      end else begin : g_narrow
         assign idx = raw_idx[IDX_W-1:0];
      end
   endgenerate

   assign hit = fixed_ok && (int'(raw_idx) <= MAX_IDX);

   if (HI_W < 0) begin : g_bad_width
      $error("ctrperm_decode: IDX_W must be at least 3");
   end
endmodule

// File: rtl/ctrperm_cond.sv
module ctrperm_cond
   import ctrperm_pkg::*;
#(
   parameter int IDX_W   = 5,
   parameter int N_SLOTS = 31
) (
   input  logic               is_write,
   input  logic [IDX_W-1:0]   idx,
   input  logic               has_fgt,
   input  logic               has_uacc,
   input  logic               has_el3,
   input  logic               el2_en,
   input  logic               el0_host,
   input  logic               host_tge,
   input  logic               hyp_trap,
   input  logic               mon_trap,
   input  logic               mon_fgt_en,
   input  logic               sdd_prio,
   input  logic               fgt_rd,
   input  logic               fgt_wr,
   input  logic               usr_all,
   input  logic               usr_rd,
   input  logic               usr_gen,
   input  logic [N_SLOTS-1:0] usr_mask,
   input  logic [IDX_W:0]     impl_cnt,
   input  logic [IDX_W:0]     acc_cnt,
   output cond_t              cond
);
   localparam int PAD_W = 2 ** IDX_W;

   logic [PAD_W-1:0] mask_pad;
   logic [IDX_W:0]   idx_ext;
   logic             mask_bit;
   logic             rd_deny;
   logic             wr_deny;
   logic             fgt_armed;
   logic             fgt_bit;
   logic             zero_rd;
   logic             zero_wr;

   generate
      if (PAD_W > N_SLOTS) begin : g_pad
         assign mask_pad = {{(PAD_W - N_SLOTS){1'b0}}, usr_mask};
      end else begin : g_nopad
         assign mask_pad = usr_mask[PAD_W-1:0];
      end
   endgenerate

   assign idx_ext  = {1'b0, idx};
   assign mask_bit = mask_pad[idx];

   // user enable gate
   always_comb begin
      if (has_uacc) begin
         rd_deny = !(usr_all || usr_rd || usr_gen);
      end else begin
         rd_deny = !(usr_rd || usr_gen);
      end
      wr_deny = !usr_gen && (!usr_all || !has_uacc);
   end

   // fine-grained trap gate
   assign fgt_armed = el2_en && has_fgt && (!has_el3 || mon_fgt_en);
   assign fgt_bit   = is_write ? fgt_wr : fgt_rd;

   // user read-zero / write-ignore gate
   assign zero_rd = has_uacc && usr_all && !mask_bit;
   assign zero_wr = has_uacc && usr_all && (!mask_bit || usr_rd);

   always_comb begin
      cond             = '0;
      cond.impl_over   = (idx_ext >= impl_cnt);
      cond.acc_over    = el2_en && (idx_ext >= acc_cnt);
      cond.user_deny   = is_write ? wr_deny : rd_deny;
      cond.user_to_el2 = el2_en && host_tge;
      cond.fgt_el1     = fgt_armed && fgt_bit;
      cond.fgt_el0     = fgt_armed && fgt_bit && !el0_host;
      cond.hyp_on      = el2_en && hyp_trap;
      cond.mon_prio    = has_el3 && sdd_prio && mon_trap;
      cond.mon_on      = has_el3 && mon_trap;
      cond.zero_user   = is_write ? zero_wr : zero_rd;
   end
endmodule

// File: rtl/ctrperm_resolve.sv
module ctrperm_resolve
   import ctrperm_pkg::*;
#(
   parameter bit UNPRED_AS_UNDEF = 1'b1
) (
   input  logic             hit,
   input  logic [1:0]       cur_el,
   input  logic             has_ctr,
   input  logic             has_fgt,
   input  logic             sdd_undef,
   input  cond_t            cond,
   output logic [OUT_W-1:0] outcome,
   output logic [5:0]       ec
);
   kind_e kind;
   kind_e kind_fixed;
   kind_e mon_kind;
   kind_e acc_kind;

   assign mon_kind = sdd_undef ? K_UNDEF : K_TRAP3;
   assign acc_kind = has_fgt ? K_TRAP2 : K_UNPRED;

   // ordered decision chain
   always_comb begin
      kind = K_NONE;
      if (!hit) begin
         kind = K_NONE;
      end else if (!has_ctr) begin
         kind = K_UNDEF;
      end else if (cond.impl_over) begin
         kind = has_fgt ? K_UNDEF : K_UNPRED;
      end else begin
         unique case (cur_el)
            2'd0: begin
               if (cond.mon_prio)         kind = K_UNDEF;
               else if (cond.user_deny)   kind = cond.user_to_el2 ? K_TRAP2 : K_TRAP1;
               else if (cond.fgt_el0)     kind = K_TRAP2;
               else if (cond.hyp_on)      kind = K_TRAP2;
               else if (cond.acc_over)    kind = acc_kind;
               else if (cond.mon_on)      kind = mon_kind;
               else if (cond.zero_user)   kind = K_ZERO;
               else                       kind = K_ACCESS;
            end
            2'd1: begin
               if (cond.mon_prio)         kind = K_UNDEF;
               else if (cond.fgt_el1)     kind = K_TRAP2;
               else if (cond.hyp_on)      kind = K_TRAP2;
               else if (cond.acc_over)    kind = acc_kind;
               else if (cond.mon_on)      kind = mon_kind;
               else                       kind = K_ACCESS;
            end
            2'd2: begin
               if (cond.mon_prio)         kind = K_UNDEF;
               else if (cond.mon_on)      kind = mon_kind;
               else                       kind = K_ACCESS;
            end
            default: kind = K_ACCESS;
         endcase
      end
   end

   // resolve the open case to a fixed kind
   generate
      if (UNPRED_AS_UNDEF) begin : g_unp_undef
         assign kind_fixed = (kind == K_UNPRED) ? K_UNDEF : kind;
      end else begin : g_unp_zero
         assign kind_fixed = (kind == K_UNPRED) ? K_ZERO : kind;
      end
   endgenerate

   always_comb begin
      outcome = '0;
      unique case (kind_fixed)
         K_ACCESS: outcome[BIT_ACCESS] = 1'b1;
         K_ZERO:   outcome[BIT_ZERO]   = 1'b1;
         K_UNDEF:  outcome[BIT_UNDEF]  = 1'b1;
         K_TRAP1:  outcome[BIT_TRAP1]  = 1'b1;
         K_TRAP2:  outcome[BIT_TRAP2]  = 1'b1;
         K_TRAP3:  outcome[BIT_TRAP3]  = 1'b1;
         default:  outcome = '0;
      endcase
   end

   assign ec = ((kind_fixed == K_TRAP1) || (kind_fixed == K_TRAP2) ||
                (kind_fixed == K_TRAP3)) ? TRAP_EC : 6'h00;
endmodule

// File: rtl/ctr_access_perm.sv
module ctr_access_perm
   import ctrperm_pkg::*;
#(
   parameter int IDX_W           = 5,
   parameter int MAX_IDX         = 30,
   parameter bit UNPRED_AS_UNDEF = 1'b1,
   localparam int N_SLOTS        = MAX_IDX + 1,
   localparam int CNT_W          = IDX_W + 1
) (
   input  logic               is_write,
   input  logic [1:0]         enc_op0,
   input  logic [2:0]         enc_op1,
   input  logic [3:0]         enc_crn,
   input  logic [3:0]         enc_crm,
   input  logic [2:0]         enc_op2,
   input  logic [1:0]         cur_el,
   input  logic               has_ctr,
   input  logic               has_fgt,
   input  logic               has_uacc,
   input  logic               has_el3,
   input  logic               el2_en,
   input  logic               el0_host,
   input  logic               host_tge,
   input  logic               hyp_trap,
   input  logic               mon_trap,
   input  logic               mon_fgt_en,
   input  logic               sdd_prio,
   input  logic               sdd_undef,
   input  logic               fgt_rd,
   input  logic               fgt_wr,
   input  logic               usr_all,
   input  logic               usr_rd,
   input  logic               usr_gen,
   input  logic [N_SLOTS-1:0] usr_mask,
   input  logic [CNT_W-1:0]   impl_cnt,
   input  logic [CNT_W-1:0]   acc_cnt,
   output logic               hit,
   output logic [IDX_W-1:0]   ctr_idx,
   output logic [OUT_W-1:0]   outcome,
   output logic [5:0]         ec
);
   if (IDX_W != 5) begin : g_bad_idx
      $error("ctr_access_perm: the encoding carries a 5-bit index, IDX_W must be 5");
   end
   if (MAX_IDX < 0 || MAX_IDX >= (2 ** IDX_W)) begin : g_bad_max
      $error("ctr_access_perm: MAX_IDX out of range for IDX_W");
   end

   cond_t cond;

   ctrperm_decode #(
      .IDX_W   (IDX_W),
      .MAX_IDX (MAX_IDX)
   ) decode_i (
      .op0 (enc_op0),
      .op1 (enc_op1),
      .crn (enc_crn),
      .crm (enc_crm),
      .op2 (enc_op2),
      .hit (hit),
      .idx (ctr_idx)
   );

   ctrperm_cond #(
      .IDX_W   (IDX_W),
      .N_SLOTS (N_SLOTS)
   ) cond_i (
      .is_write   (is_write),
      .idx        (ctr_idx),
      .has_fgt    (has_fgt),
      .has_uacc   (has_uacc),
      .has_el3    (has_el3),
      .el2_en     (el2_en),
      .el0_host   (el0_host),
      .host_tge   (host_tge),
      .hyp_trap   (hyp_trap),
      .mon_trap   (mon_trap),
      .mon_fgt_en (mon_fgt_en),
      .sdd_prio   (sdd_prio),
      .fgt_rd     (fgt_rd),
      .fgt_wr     (fgt_wr),
      .usr_all    (usr_all),
      .usr_rd     (usr_rd),
      .usr_gen    (usr_gen),
      .usr_mask   (usr_mask),
      .impl_cnt   (impl_cnt),
      .acc_cnt    (acc_cnt),
      .cond       (cond)
   );

   ctrperm_resolve #(
      .UNPRED_AS_UNDEF (UNPRED_AS_UNDEF)
   ) resolve_i (
      .hit       (hit),
      .cur_el    (cur_el),
      .has_ctr   (has_ctr),
      .has_fgt   (has_fgt),
      .sdd_undef (sdd_undef),
      .cond      (cond),
      .outcome   (outcome),
      .ec        (ec)
   );
endmodule

// File: rtl/ctr_access_perm_chk.sv
module ctr_access_perm_chk
   import ctrperm_pkg::*;
#(
   parameter int IDX_W           = 5,
   parameter bit UNPRED_AS_UNDEF = 1'b1
) (
   input logic             hit,
   input logic [1:0]       cur_el,
   input logic             has_ctr,
   input logic             has_uacc,
   input logic             usr_all,
   input logic [IDX_W:0]   impl_cnt,
   input logic [IDX_W-1:0] ctr_idx,
   input logic [OUT_W-1:0] outcome,
   input logic [5:0]       ec
);
   always_comb begin
      // R1
      one_kind_chk: assert ($countones(outcome) == (hit ? 1 : 0));
      // R2
      no_feature_chk: assert (!(hit && !has_ctr) || outcome[BIT_UNDEF]);
      // R9
      el3_open_chk: assert (!(hit && has_ctr && cur_el == 2'd3 &&
                              {1'b0, ctr_idx} < impl_cnt) || outcome[BIT_ACCESS]);
      // R5
      el1_target_chk: assert (!outcome[BIT_TRAP1] || cur_el == 2'd0);
      // R10
      zero_source_chk: assert (!outcome[BIT_ZERO] || !UNPRED_AS_UNDEF ||
                               (cur_el == 2'd0 && has_uacc && usr_all));
      // R12
      trap_class_chk: assert ((ec == TRAP_EC) == (|outcome[BIT_TRAP3:BIT_TRAP1]));
      // R12
      class_value_chk: assert (ec == TRAP_EC || ec == 6'h00);
   end
endmodule

bind ctr_access_perm ctr_access_perm_chk #(
   .IDX_W           (IDX_W),
   .UNPRED_AS_UNDEF (UNPRED_AS_UNDEF)
) chk_i (
   .hit      (hit),
   .cur_el   (cur_el),
   .has_ctr  (has_ctr),
   .has_uacc (has_uacc),
   .usr_all  (usr_all),
   .impl_cnt (impl_cnt),
   .ctr_idx  (ctr_idx),
   .outcome  (outcome),
   .ec       (ec)
);

// File: tb/ctr_access_perm_tb.sv
`timescale 1ns/1ps
module ctr_access_perm_tb_top;
   localparam logic [5:0] O_ACC = 6'b000001;
   localparam logic [5:0] O_ZER = 6'b000010;
   localparam logic [5:0] O_UND = 6'b000100;
   localparam logic [5:0] O_T1  = 6'b001000;
   localparam logic [5:0] O_T2  = 6'b010000;
   localparam logic [5:0] O_T3  = 6'b100000;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        is_write;
   logic [1:0]  enc_op0;
   logic [2:0]  enc_op1;
   logic [3:0]  enc_crn, enc_crm;
   logic [2:0]  enc_op2;
   logic [1:0]  cur_el;
   logic        has_ctr, has_fgt, has_uacc, has_el3, el2_en, el0_host, host_tge;
   logic        hyp_trap, mon_trap, mon_fgt_en, sdd_prio, sdd_undef, fgt_rd, fgt_wr;
   logic        usr_all, usr_rd, usr_gen;
   logic [30:0] usr_mask;
   logic [5:0]  impl_cnt, acc_cnt;
   logic        hit;
   logic [4:0]  ctr_idx;
   logic [5:0]  outcome, ec;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;
   logic [31:0] rs = 32'h1234_5678;

   ctr_access_perm dut_i (.*);

   task automatic idle();
      {is_write, enc_op0, enc_op1, enc_crn, enc_crm, enc_op2, cur_el} = '0;
      {has_ctr, has_fgt, has_uacc, has_el3, el2_en, el0_host, host_tge} = '0;
      {hyp_trap, mon_trap, mon_fgt_en, sdd_prio, sdd_undef, fgt_rd, fgt_wr} = '0;
      {usr_all, usr_rd, usr_gen} = '0;
      usr_mask = '0; impl_cnt = '0; acc_cnt = '0;
   endtask

   // permissive baseline: counter feature, all counters present and accessible
   task automatic base(input logic [1:0] el, input logic wr, input logic [4:0] idx);
      idle();
      cur_el = el; is_write = wr;
      enc_op0 = 2'd3; enc_op1 = 3'd3; enc_crn = 4'd14;
      enc_crm = {2'b10, idx[4:3]}; enc_op2 = idx[2:0];
      has_ctr = 1'b1; usr_gen = 1'b1; usr_mask = '1;
      impl_cnt = 6'd31; acc_cnt = 6'd31;
   endtask

   task automatic chk(input string tag, input logic exp_hit, input logic [4:0] exp_idx,
                      input logic [5:0] exp_o);
      logic [5:0] exp_ec;
      exp_ec = (exp_o[5:3] != 3'b000) ? 6'h18 : 6'h00;
      #1;
      n_chk++;
      if (hit !== exp_hit || outcome !== exp_o || ec !== exp_ec ||
          (exp_hit && ctr_idx !== exp_idx)) begin
         n_err++;
         $display("FAIL %s: hit=%b idx=%0d outcome=%b ec=%h, expected hit=%b idx=%0d outcome=%b ec=%h",
                  tag, hit, ctr_idx, outcome, ec, exp_hit, exp_idx, exp_o, exp_ec);
      end
   endtask

   function automatic logic [5:0] model();
      logic [4:0] m;
      logic mb, deny, fgt_ok, fbit, zero;
      logic [5:0] mon_o, acc_o;
      m  = {enc_crm[1:0], enc_op2};
      mb = usr_mask[m];
      if (!(enc_op0 == 3 && enc_op1 == 3 && enc_crn == 14 && enc_crm[3:2] == 2'b10 && m != 31))
         return 6'b0;
      if (!has_ctr) return O_UND;
      if ({1'b0, m} >= impl_cnt) return O_UND;
      if (cur_el == 3) return O_ACC;
      if (has_el3 && sdd_prio && mon_trap) return O_UND;
      mon_o  = sdd_undef ? O_UND : O_T3;
      acc_o  = has_fgt ? O_T2 : O_UND;
      fgt_ok = el2_en && has_fgt && (!has_el3 || mon_fgt_en);
      fbit   = is_write ? fgt_wr : fgt_rd;
      if (cur_el == 2) return (has_el3 && mon_trap) ? mon_o : O_ACC;
      if (cur_el == 0) begin
         if (is_write) deny = !usr_gen && !(has_uacc && usr_all);
         else deny = has_uacc ? !(usr_all || usr_rd || usr_gen) : !(usr_rd || usr_gen);
         if (deny) return (el2_en && host_tge) ? O_T2 : O_T1;
         if (fgt_ok && fbit && !el0_host) return O_T2;
      end else if (fgt_ok && fbit) return O_T2;
      if (el2_en && hyp_trap) return O_T2;
      if (el2_en && {1'b0, m} >= acc_cnt) return acc_o;
      if (has_el3 && mon_trap) return mon_o;
      if (cur_el == 0) begin
         zero = has_uacc && usr_all && (!mb || (is_write && usr_rd));
         if (zero) return O_ZER;
      end
      return O_ACC;
   endfunction

   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] x;
      x = s ^ (s << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      return x;
   endfunction

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      idle();
      @(negedge clk); chk("R1 idle", 1'b0, 5'd0, 6'b0);
      @(negedge clk); base(2'd3, 1'b0, 5'd7); enc_crn = 4'd13; chk("R1 wrong CRn", 1'b0, 5'd0, 6'b0);
      @(negedge clk); base(2'd3, 1'b0, 5'd7); enc_crm = 4'b1110; chk("R1 wrong CRm", 1'b0, 5'd0, 6'b0);
      @(negedge clk); base(2'd3, 1'b0, 5'd31); chk("R1 index 31", 1'b0, 5'd0, 6'b0);
      @(negedge clk); base(2'd3, 1'b1, 5'd30); chk("R1 R9 el3 idx30", 1'b1, 5'd30, O_ACC);
      @(negedge clk); base(2'd1, 1'b0, 5'd9); has_ctr = 1'b0; chk("R2 no feature", 1'b1, 5'd9, O_UND);
      @(negedge clk); base(2'd3, 1'b0, 5'd5); impl_cnt = 6'd5; has_fgt = 1'b1; chk("R3 over impl fgt", 1'b1, 5'd5, O_UND);
      @(negedge clk); base(2'd1, 1'b0, 5'd5); impl_cnt = 6'd5; chk("R11 over impl resolved", 1'b1, 5'd5, O_UND);
      @(negedge clk); base(2'd1, 1'b0, 5'd4); impl_cnt = 6'd5; chk("R3 below impl", 1'b1, 5'd4, O_ACC);
      @(negedge clk); base(2'd1, 1'b0, 5'd2); has_el3 = 1; mon_trap = 1; sdd_prio = 1; chk("R4 el1 prio", 1'b1, 5'd2, O_UND);
      @(negedge clk); base(2'd0, 1'b0, 5'd2); usr_gen = 0; has_el3 = 1; mon_trap = 1; sdd_prio = 1; chk("R4 el0 beats deny", 1'b1, 5'd2, O_UND);
      @(negedge clk); base(2'd1, 1'b0, 5'd2); has_el3 = 1; mon_trap = 1; chk("R8 trap el3", 1'b1, 5'd2, O_T3);
      @(negedge clk); base(2'd1, 1'b0, 5'd2); has_el3 = 1; mon_trap = 1; sdd_undef = 1; chk("R8 sdd undef", 1'b1, 5'd2, O_UND);
      @(negedge clk); base(2'd1, 1'b0, 5'd2); mon_trap = 1; chk("R8 no el3", 1'b1, 5'd2, O_ACC);
      @(negedge clk); base(2'd0, 1'b0, 5'd3); usr_gen = 0; has_uacc = 1; chk("R5 read deny el1", 1'b1, 5'd3, O_T1);
      @(negedge clk); base(2'd0, 1'b0, 5'd3); usr_gen = 0; el2_en = 1; host_tge = 1; chk("R5 read deny el2", 1'b1, 5'd3, O_T2);
      @(negedge clk); base(2'd0, 1'b0, 5'd3); usr_gen = 0; usr_all = 1; chk("R5 old level ignores all", 1'b1, 5'd3, O_T1);
      @(negedge clk); base(2'd0, 1'b0, 5'd3); usr_gen = 0; usr_rd = 1; chk("R5 read enable", 1'b1, 5'd3, O_ACC);
      @(negedge clk); base(2'd0, 1'b1, 5'd3); usr_gen = 0; usr_rd = 1; chk("R5 write needs gen", 1'b1, 5'd3, O_T1);
      @(negedge clk); base(2'd0, 1'b1, 5'd3); usr_gen = 0; usr_all = 1; has_uacc = 1; chk("R5 write via all", 1'b1, 5'd3, O_ACC);
      @(negedge clk); base(2'd1, 1'b0, 5'd6); el2_en = 1; has_fgt = 1; fgt_rd = 1; chk("R6 fgt read", 1'b1, 5'd6, O_T2);
      @(negedge clk); base(2'd1, 1'b1, 5'd6); el2_en = 1; has_fgt = 1; fgt_rd = 1; chk("R6 fgt write bit", 1'b1, 5'd6, O_ACC);
      @(negedge clk); base(2'd1, 1'b0, 5'd6); el2_en = 1; has_fgt = 1; fgt_rd = 1; has_el3 = 1; chk("R6 el3 gate", 1'b1, 5'd6, O_ACC);
      @(negedge clk); base(2'd0, 1'b1, 5'd6); el2_en = 1; has_fgt = 1; fgt_wr = 1; el0_host = 1; chk("R6 host skip", 1'b1, 5'd6, O_ACC);
      @(negedge clk); base(2'd0, 1'b1, 5'd6); el2_en = 1; has_fgt = 1; fgt_wr = 1; has_el3 = 1; mon_fgt_en = 1; mon_trap = 1; chk("R6 beats el3", 1'b1, 5'd6, O_T2);
      @(negedge clk); base(2'd1, 1'b0, 5'd8); el2_en = 1; hyp_trap = 1; chk("R7 hyp trap", 1'b1, 5'd8, O_T2);
      @(negedge clk); base(2'd1, 1'b0, 5'd8); hyp_trap = 1; acc_cnt = 6'd2; chk("R7 el2 off", 1'b1, 5'd8, O_ACC);
      @(negedge clk); base(2'd0, 1'b0, 5'd8); el2_en = 1; acc_cnt = 6'd8; has_fgt = 1; chk("R7 acc fgt", 1'b1, 5'd8, O_T2);
      @(negedge clk); base(2'd1, 1'b0, 5'd8); el2_en = 1; acc_cnt = 6'd8; chk("R7 acc unpred", 1'b1, 5'd8, O_UND);
      @(negedge clk); base(2'd2, 1'b0, 5'd8); el2_en = 1; hyp_trap = 1; has_fgt = 1; fgt_rd = 1; acc_cnt = 0; chk("R9 el2 open", 1'b1, 5'd8, O_ACC);
      @(negedge clk); base(2'd2, 1'b1, 5'd8); has_el3 = 1; mon_trap = 1; chk("R9 el2 mon", 1'b1, 5'd8, O_T3);
      @(negedge clk); base(2'd0, 1'b0, 5'd11); has_uacc = 1; usr_all = 1; usr_mask[11] = 0; chk("R10 read zero", 1'b1, 5'd11, O_ZER);
      @(negedge clk); base(2'd0, 1'b0, 5'd11); has_uacc = 1; usr_all = 1; usr_rd = 1; chk("R10 read allowed", 1'b1, 5'd11, O_ACC);
      @(negedge clk); base(2'd0, 1'b1, 5'd11); has_uacc = 1; usr_all = 1; usr_rd = 1; chk("R10 write ignored", 1'b1, 5'd11, O_ZER);
      @(negedge clk); base(2'd0, 1'b1, 5'd11); usr_all = 1; usr_mask[11] = 0; chk("R10 old level", 1'b1, 5'd11, O_ACC);

      for (int i = 0; i < 20000; i++) begin
         logic [31:0] a, b;
         @(negedge clk);
         rs = nxt(rs); a = rs; rs = nxt(rs); b = rs;
         base(i[1:0], i[2], (a[4:0] == 5'd31) ? 5'd30 : a[4:0]);
         has_ctr = (a[7:5] != 0); has_fgt = a[8]; has_uacc = a[9]; has_el3 = a[10];
         el2_en = a[11]; el0_host = a[12]; host_tge = a[13];
         hyp_trap = (a[16:14] == 0); mon_trap = (a[19:17] == 0); mon_fgt_en = a[20];
         sdd_prio = a[21]; sdd_undef = a[22]; fgt_rd = (a[24:23] == 0); fgt_wr = (a[26:25] == 0);
         usr_all = a[27]; usr_rd = a[28]; usr_gen = a[29];
         usr_mask = b[30:0]; impl_cnt = {1'b0, b[31] ? 5'd31 : a[4:0] ^ 5'd3} + (b[0] ? 6'd0 : 6'd1);
         acc_cnt = (a[30]) ? 6'd31 : {1'b0, b[5:1]};
         if (i % 512 == 3) enc_op2 = ~enc_op2 ^ 3'd1;
         if (i % 777 == 5) enc_op1 = 3'd2;
         chk("R12 sweep", model() != 6'b0, {enc_crm[1:0], enc_op2}, model());
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule